// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster from values that software writes into a small register set. Two counters walk the pixel position within a line and the line position within a frame. Comparators on those counters derive the horizontal and vertical sync pulses, a display-enable window, a composite sync for video-carried sync, and a one-cycle prefetch strobe at a programmable column of every line. The block also holds the panning origin that the refresh logic reads for each frame.

Every timing value is written as the position of its event minus one. The total registers therefore hold the last counter value, and the display registers hold the last active pixel or line. A sync pulse starts one count after its start register and ends on the count in its end register. While the generator runs, timing and origin writes go to a holding copy. That copy becomes active when the frame wraps, so a mode change never tears a frame. While the generator is stopped, writes take effect on the next cycle. Polarity, suppression and blanking controls act at once. They are used for the power-saving blanking states, where one or both syncs are held at their inactive level.

Registers are written through one port: `cfg_we`, a 4-bit `cfg_addr` and 32-bit `cfg_wdata`. Address decoding is listed with each requirement below.

Top module: `raster_timing_gen`

## Requirements
- R1: When running, the pixel counter counts 0 up to the line-total register (address 1) and then returns to 0. At each such return the line counter advances, and it returns to 0 after the frame-total register value (address 5).
- R2: Before inversion, hsync is high for pixel counts greater than the hsync-start register (address 3) and not above the hsync-end register (address 4). Vsync is high for line counts greater than the vsync-start register (address 7) and not above the vsync-end register (address 8).
- R3: Display enable is high when the pixel count is at or below the active-width register (address 2), the line count is at or below the active-height register (address 6), and control bits 0 and 1 are both set.
- R4: The prefetch strobe is high for exactly the cycle in which the pixel count equals the prefetch-column register (address 9) while running.
- R5: In the control register (address 0), bit 0 runs the counters. With bit 0 clear the counters are held at zero and both syncs stay inactive. With bit 1 (refresh) clear, display enable is low while the counters keep running.
- R6: In the sync-control register (address 10), bit 3 inverts hsync and bit 4 inverts vsync.
- R7: In the sync-control register, bit 5 suppresses hsync, bit 6 suppresses vsync and bit 1 suppresses both. A suppressed sync sits at its inactive level: low when not inverted, high when inverted.
- R8: Sync-control bit 0 drives `csync_o` with the OR of the unsuppressed active-high syncs. With bit 0 clear, `csync_o` is low.
- R9: Bit 1 of the display-control register (address 11) forces display enable low, and the syncs keep running.
- R10: A timing write made while running changes nothing until the frame wraps, and applies from the first cycle of the next frame. A write made while stopped applies before the next run.
- R11: The origin register (address 12) takes x in bits [31:16] and y in bits [15:0]. A write whose x is not a multiple of 8 is ignored. The origin outputs pick up a new origin at the next frame start.
- R12: After reset, the generator is stopped, every output is low, and the timing registers hold a 1280x1024 mode. That mode has line total 1687, active width 1279, hsync 1327/1439, frame total 1065, active height 1023, vsync 1024/1027 and prefetch column 1332.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after suppression and polarity |
| vsync_o | output | 1 | Vertical sync after suppression and polarity |
| csync_o | output | 1 | Composite sync for sync carried on video |
| de_o | output | 1 | Display enable |
| prefetch_o | output | 1 | Per-line early fetch strobe |
| pix_x_o | output | CNT_W | Pixel counter |
| line_y_o | output | CNT_W | Line counter |
| org_x_o | output | 16 | Active panning origin x |
| org_y_o | output | 16 | Active panning origin y |

## Verification
On every cycle, the assertions check the following:
- the pixel counter stays within the active line total and steps by one between wraps;
- stopped counters sit at zero;
- suppressed syncs hold their inactive level, and display-off keeps enable low;
- the prefetch strobe lasts one cycle;
- the active timing set changes only on a frame load.

The exact pulse positions, the polarity and composite-sync combinations, and the frame-boundary hand-over of timing and origin writes made mid-frame are shown only by the bench's sweeps. Those sweeps compare every output against counter positions computed arithmetically.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_HTOT   = 4'd1,
        A_HDISP  = 4'd2,
        A_HSS    = 4'd3,
        A_HSE    = 4'd4,
        A_VTOT   = 4'd5,
        A_VDISP  = 4'd6,
        A_VSS    = 4'd7,
        A_VSE    = 4'd8,
        A_PFCOL  = 4'd9,
        A_SYNC   = 4'd10,
        A_DISP   = 4'd11,
        A_ORIGIN = 4'd12
    } reg_addr_e;

    typedef struct packed {
        logic [REG_W-1:0] htot;
        logic [REG_W-1:0] hdisp;
        logic [REG_W-1:0] hss;
        logic [REG_W-1:0] hse;
        logic [REG_W-1:0] vtot;
        logic [REG_W-1:0] vdisp;
        logic [REG_W-1:0] vss;
        logic [REG_W-1:0] vse;
        logic [REG_W-1:0] pfcol;
    } timing_t;

    typedef struct packed {
        logic [REG_W-1:0] x;
        logic [REG_W-1:0] y;
    } origin_t;

    typedef struct packed {
        logic rgb_sync;
        logic all_off;
        logic h_inv;
        logic v_inv;
        logic h_off;
        logic v_off;
    } sync_cfg_t;

    // 1280x1024: porches 48/112/248 pixels and 1/3/38 lines, all minus one
    localparam timing_t REF_TIMING = '{
        htot:  16'd1687,
        hdisp: 16'd1279,
        hss:   16'd1327,
        hse:   16'd1439,
        vtot:  16'd1065,
        vdisp: 16'd1023,
        vss:   16'd1024,
        vse:   16'd1027,
        pfcol: 16'd1332
    };

endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_load,
    output logic              run,
    output logic              refresh,
    output logic              disp_off,
    output sync_cfg_t         sync_cfg,
    output timing_t           act,
    output origin_t           org
);

    typedef struct packed {
        timing_t   shd;
        timing_t   act;
        origin_t   org_shd;
        origin_t   org_act;
        logic      run;
        logic      refresh;
        logic      doff;
        sync_cfg_t sync;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // frame boundary or stopped: holding copy becomes active
        if (frame_load) begin
            st_d.act     = st_q.shd;
            st_d.org_act = st_q.org_shd;
        end
        if (we) begin
            case (reg_addr_e'(addr))
                A_CTRL: begin
                    st_d.run     = wdata[0];
                    st_d.refresh = wdata[1];
                end
                A_HTOT:  st_d.shd.htot  = wdata[REG_W-1:0];
                A_HDISP: st_d.shd.hdisp = wdata[REG_W-1:0];
                A_HSS:   st_d.shd.hss   = wdata[REG_W-1:0];
                A_HSE:   st_d.shd.hse   = wdata[REG_W-1:0];
                A_VTOT:  st_d.shd.vtot  = wdata[REG_W-1:0];
                A_VDISP: st_d.shd.vdisp = wdata[REG_W-1:0];
                A_VSS:   st_d.shd.vss   = wdata[REG_W-1:0];
                A_VSE:   st_d.shd.vse   = wdata[REG_W-1:0];
                A_PFCOL: st_d.shd.pfcol = wdata[REG_W-1:0];
                A_SYNC: begin
                    st_d.sync.rgb_sync = wdata[0];
                    st_d.sync.all_off  = wdata[1];
                    st_d.sync.h_inv    = wdata[3];
                    st_d.sync.v_inv    = wdata[4];
                    st_d.sync.h_off    = wdata[5];
                    st_d.sync.v_off    = wdata[6];
                end
                A_DISP: st_d.doff = wdata[1];
                A_ORIGIN: begin
                    // x origin must sit on an 8-pixel boundary
                    if (wdata[REG_W+2:REG_W] == 3'b000) begin
                        st_d.org_shd.x = wdata[DATA_W-1:REG_W];
                        st_d.org_shd.y = wdata[REG_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.shd <= REF_TIMING;
            st_q.act <= REF_TIMING;
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.run;
    assign refresh  = st_q.refresh;
    assign disp_off = st_q.doff;
    assign sync_cfg = st_q.sync;
    assign act      = st_q.act;
    assign org      = st_q.org_act;

endmodule

// File: rtl/rtg_axis_cnt.sv
module rtg_axis_cnt
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [REG_W-1:0] last,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = step && (REG_W'(st_q.cnt) >= last);
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rtg_video_out.sv
module rtg_video_out
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             run,
    input  logic             refresh,
    input  logic             disp_off,
    input  sync_cfg_t        sync_cfg,
    input  timing_t          act,
    input  logic [CNT_W-1:0] x,
    input  logic [CNT_W-1:0] y,
    output logic             hsync,
    output logic             vsync,
    output logic             csync,
    output logic             de,
    output logic             prefetch
);

    logic [REG_W-1:0] xe, ye;
    logic hs_raw, vs_raw, hs_eff, vs_eff;

    always_comb begin
        xe       = REG_W'(x);
        ye       = REG_W'(y);
        hs_raw   = run && (xe > act.hss) && (xe <= act.hse);
        vs_raw   = run && (ye > act.vss) && (ye <= act.vse);
        // suppression first, polarity last, so a held sync stays inactive
        hs_eff   = hs_raw && !sync_cfg.all_off && !sync_cfg.h_off;
        vs_eff   = vs_raw && !sync_cfg.all_off && !sync_cfg.v_off;
        hsync    = hs_eff ^ sync_cfg.h_inv;
        vsync    = vs_eff ^ sync_cfg.v_inv;
        csync    = sync_cfg.rgb_sync && (hs_eff || vs_eff);
        de       = run && refresh && !disp_off
                   && (xe <= act.hdisp) && (ye <= act.vdisp);
        prefetch = run && (xe == act.pfcol);
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              csync_o,
    output logic              de_o,
    output logic              prefetch_o,
    output logic [CNT_W-1:0]  pix_x_o,
    output logic [CNT_W-1:0]  line_y_o,
    output logic [REG_W-1:0]  org_x_o,
    output logic [REG_W-1:0]  org_y_o
);

    logic      run, refresh, disp_off;
    sync_cfg_t sync_cfg;
    timing_t   act_tim;
    origin_t   org;
    logic      h_wrap, v_wrap, frame_load;

    assign frame_load = !run || v_wrap;

    rtg_regfile regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .frame_load (frame_load),
        .run        (run),
        .refresh    (refresh),
        .disp_off   (disp_off),
        .sync_cfg   (sync_cfg),
        .act        (act_tim),
        .org        (org)
    );

    rtg_axis_cnt #(.CNT_W(CNT_W)) hcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run),
        .step  (run),
        .last  (act_tim.htot),
        .cnt   (pix_x_o),
        .wrap  (h_wrap)
    );

    rtg_axis_cnt #(.CNT_W(CNT_W)) vcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run),
        .step  (h_wrap),
        .last  (act_tim.vtot),
        .cnt   (line_y_o),
        .wrap  (v_wrap)
    );

    rtg_video_out #(.CNT_W(CNT_W)) vout_i (
        .run      (run),
        .refresh  (refresh),
        .disp_off (disp_off),
        .sync_cfg (sync_cfg),
        .act      (act_tim),
        .x        (pix_x_o),
        .y        (line_y_o),
        .hsync    (hsync_o),
        .vsync    (vsync_o),
        .csync    (csync_o),
        .de       (de_o),
        .prefetch (prefetch_o)
    );

    assign org_x_o = org.x;
    assign org_y_o = org.y;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             frame_load,
    input logic [CNT_W-1:0] pix_x,
    input logic [CNT_W-1:0] line_y,
    input timing_t          act,
    input sync_cfg_t        sync_cfg,
    input logic             disp_off,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             de_o,
    input logic             prefetch_o
);

    p_x_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (REG_W'(pix_x) <= act.htot));

    p_x_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (REG_W'($past(pix_x)) < $past(act.htot)))
        |-> (pix_x == CNT_W'($past(pix_x) + 1'b1)));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (pix_x == '0 && line_y == '0));

    p_hsync_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_cfg.h_off || sync_cfg.all_off) |-> (hsync_o == sync_cfg.h_inv));

    p_vsync_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_cfg.v_off || sync_cfg.all_off) |-> (vsync_o == sync_cfg.v_inv));

    p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_off |-> !de_o);

    p_pf_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_o && act.htot != '0) |=> !prefetch_o);

    p_act_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_load) |=> $stable(act));

endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .frame_load (frame_load),
    .pix_x      (pix_x_o),
    .line_y     (line_y_o),
    .act        (act_tim),
    .sync_cfg   (sync_cfg),
    .disp_off   (disp_off),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .de_o       (de_o),
    .prefetch_o (prefetch_o)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          hsync_o, vsync_o, csync_o, de_o, prefetch_o;
    logic [CW-1:0] pix_x_o, line_y_o;
    logic [15:0]   org_x_o, org_y_o;

    raster_timing_gen #(.CNT_W(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .csync_o    (csync_o),
        .de_o       (de_o),
        .prefetch_o (prefetch_o),
        .pix_x_o    (pix_x_o),
        .line_y_o   (line_y_o),
        .org_x_o    (org_x_o),
        .org_y_o    (org_y_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model: active and pending timing, controls, counters
    int ht = 1687, hd = 1279, hss = 1327, hse = 1439;
    int vt = 1065, vd = 1023, vss = 1024, vse = 1027, pf = 1332;
    int p_ht = 1687, p_hd = 1279, p_hss = 1327, p_hse = 1439;
    int p_vt = 1065, p_vd = 1023, p_vss = 1024, p_vse = 1027, p_pf = 1332;
    int ox = 0, oy = 0, pox = 0, poy = 0;
    int en = 0, refr = 0, doff = 0;
    logic [6:0] sc = '0;
    int ex = 0, ey = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (x=%0d y=%0d)",
                     req, what, act, exp, ex, ey);
        end
    endtask

    task automatic load_pending();
        ht = p_ht; hd = p_hd; hss = p_hss; hse = p_hse;
        vt = p_vt; vd = p_vd; vss = p_vss; vse = p_vse; pf = p_pf;
        ox = pox; oy = poy;
    endtask

    task automatic advance();
        if (en != 0) begin
            ex++;
            if (ex > ht) begin
                ex = 0;
                ey++;
                if (ey > vt) begin
                    ey = 0;
                    load_pending();
                end
            end
        end else begin
            ex = 0;
            ey = 0;
            load_pending();
        end
    endtask

    task automatic compare_all(string stag, string gtag);
        bit hr, vr, he, ve;
        hr = (en != 0) && ex > hss && ex <= hse;
        vr = (en != 0) && ey > vss && ey <= vse;
        he = hr && !sc[1] && !sc[5];
        ve = vr && !sc[1] && !sc[6];
        chk("R1", "pix_x", pix_x_o, ex);
        chk("R1", "line_y", line_y_o, ey);
        chk(stag, "hsync", hsync_o, he ^ sc[3]);
        chk(stag, "vsync", vsync_o, ve ^ sc[4]);
        chk("R8", "csync", csync_o, sc[0] && (he || ve));
        chk(gtag, "de", de_o,
            (en != 0) && (refr != 0) && (doff == 0) && ex <= hd && ey <= vd);
        chk("R4", "prefetch", prefetch_o, (en != 0) && ex == pf);
        if (en != 0) begin
            chk("R11", "org_x", org_x_o, ox);
            chk("R11", "org_y", org_y_o, oy);
        end
    endtask

    task automatic run(int n, string stag, string gtag);
        repeat (n) begin
            compare_all(stag, gtag);
            @(negedge clk);
            advance();
        end
    endtask

    task automatic run_to(int y, int x);
        while (!(ey == y && ex == x)) begin
            compare_all("R2", "R3");
            @(negedge clk);
            advance();
        end
    endtask

    task automatic wr(int a, int unsigned d);
        cfg_we    = 1'b1;
        cfg_addr  = a[3:0];
        cfg_wdata = d;
        @(negedge clk);
        advance();
        cfg_we = 1'b0;
        case (a)
            0: begin en = int'(d & 1); refr = int'((d >> 1) & 1); end
            1: p_ht  = int'(d);
            2: p_hd  = int'(d);
            3: p_hss = int'(d);
            4: p_hse = int'(d);
            5: p_vt  = int'(d);
            6: p_vd  = int'(d);
            7: p_vss = int'(d);
            8: p_vse = int'(d);
            9: p_pf  = int'(d);
            10: sc = d[6:0];
            11: doff = int'((d >> 1) & 1);
            12: if (((d >> 16) & 7) == 0) begin
                    pox = int'(d >> 16);
                    poy = int'(d & 32'hffff);
                end
            default: ;
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "hsync", hsync_o, 0);
        chk("R12", "vsync", vsync_o, 0);
        chk("R12", "csync", csync_o, 0);
        chk("R12", "de", de_o, 0);
        chk("R12", "prefetch", prefetch_o, 0);
        chk("R12", "pix_x", pix_x_o, 0);
        chk("R12", "org_x", org_x_o, 0);
        // R5: stopped counters stay at zero
        run(20, "R5", "R5");
        // R12: reference mode, first line and a bit
        wr(0, 3);
        run(1700, "R12", "R12");
        wr(0, 0);
        run(3, "R5", "R5");
        // small mode: 20 pixels x 11 lines
        wr(1, 19); wr(2, 11); wr(3, 13); wr(4, 16);
        wr(5, 10); wr(6, 5);  wr(7, 6);  wr(8, 8);
        wr(9, 15); wr(12, (8 << 16) | 3);
        wr(0, 3);
        run(440, "R2", "R3");
        // R6: polarity
        wr(10, 'h18);  run(220, "R6", "R3");
        // R7: suppression, with and without inversion
        wr(10, 'h38);  run(220, "R7", "R3");
        wr(10, 'h40);  run(220, "R7", "R3");
        wr(10, 'h02);  run(220, "R7", "R3");
        wr(10, 'h1A);  run(120, "R7", "R3");
        // R8: composite sync
        wr(10, 'h01);  run(220, "R8", "R3");
        wr(10, 0);
        // R9: display off
        wr(11, 2);     run(220, "R2", "R9");
        wr(11, 0);
        // R5: refresh off keeps counters running
        wr(0, 1);      run(220, "R2", "R5");
        wr(0, 3);
        // R10, R11: writes mid-frame wait for the frame boundary
        run_to(2, 5);
        wr(2, 7); wr(1, 23); wr(9, 3);
        wr(12, (24 << 16) | 5);
        wr(12, (13 << 16) | 9);
        run(560, "R2", "R10");
        // R5, R10: stop, write while stopped, restart
        wr(0, 0);      run(4, "R5", "R5");
        wr(2, 9);
        wr(0, 3);      run(300, "R2", "R10");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule